// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter with four multiplexed analog inputs. Software reaches it through a small byte-wide register port. Two configuration registers hold the enable, start/busy flag, input channel, reference choice, result layout and conversion clock choice. The two result registers present the 10-bit code in one of two layouts. The mux, sample-and-hold, trial DAC and comparator sit outside the block. The block drives the channel select, the reference select and the trial code, and it reads back a single comparator bit.

Each conversion is timed by a conversion clock. That clock is either the system clock divided by a power of two from 2 to 64, or a one-cycle tick from an external RC oscillator. A conversion always takes eleven of these periods. The first is a setup period. The other ten each decide one result bit, starting from the MSB. When the last bit is decided, the result is stored, the busy flag drops and a one-cycle done pulse is raised. Software can abort a running conversion by writing the start flag to zero.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, all four registers read 0x00, `conv_done` is 0, `dac_code` is 0, and `mux_sel` and `ref_sel` are 0.
- R2: The control register is at address 0. Bit 0 is enable, bit 1 is start/busy, bits 3:2 are the channel, bit 6 is the reference select and bit 7 is the format. Writing bit 1 as 1 together with bit 0 as 1 while idle starts a conversion, and bit 1 then reads 1. A start written with bit 0 clear is ignored: the block stays idle and raises no done pulse.
- R3: The clock select is bits 6:4 of the register at address 1. Codes 000, 100, 001, 101, 010 and 110 make each conversion-clock period 2, 4, 8, 16, 32 and 64 system cycles. A whole conversion lasts 11 periods, so `conv_done` is high exactly 11·N cycles after the clock edge that accepted the start.
- R4: When the low two bits of the clock select are 11, periods advance only on cycles where `rc_tick` is high. Without ticks, the conversion stays busy indefinitely.
- R5: `dac_code` is 0 while idle and during the setup period. The first trial after setup is 0x200. A trial bit is kept when `cmp_in` is 1 (input ≥ trial) and cleared otherwise, so an ideal comparator makes the result equal the input code.
- R6: Address 2 is the high result register and address 3 is the low one. With format bit 1, high = {6'b0, r[9:8]} and low = r[7:0]. With format bit 0, high = r[9:2] and low = {r[1:0], 6'b0}.
- R7: `conv_done` is a one-cycle pulse. It rises in the same cycle in which the busy bit reads 0 and the new result is visible.
- R8: Writing the control register with bit 1 or bit 0 clear during a conversion stops it at the next edge. The result registers are left unchanged and no done pulse follows.
- R9: While idle, `mux_sel` and `ref_sel` follow control bits 3:2 and bit 6. During a conversion they hold the values written with the start, even if the control register is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational on addr) |
| rc_tick | input | 1 | One-cycle tick from the external RC clock |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial level |
| dac_code | output | 10 | Trial code to the DAC |
| mux_sel | output | 2 | Analog input channel select |
| ref_sel | output | 1 | 1 = external reference pin, 0 = supply |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A corrupted period counter or clock-select decode changes the latency of the done pulse. The bench counts that latency to the cycle for every divider code. A wrong trial mask or a wrong keep decision gives a result code that differs from the modelled input. This shows when the result is read back after the same conversion, and an early trial shows at `dac_code` one period after setup. Channel or reference values that are not held during a conversion make the comparator model use the wrong input, so the error is visible both on `mux_sel` straight away and in the stored result.

// File: rtl/sar_seq_pkg.sv
// Shared constants for the SAR conversion sequencer: register addresses,
// control bit positions and the clock-select decode helpers.
package sar_seq_pkg;

    localparam logic [1:0] A_CTL    = 2'd0;
    localparam logic [1:0] A_CLKCFG = 2'd1;
    localparam logic [1:0] A_RES_HI = 2'd2;
    localparam logic [1:0] A_RES_LO = 2'd3;

    localparam int B_EN  = 0;
    localparam int B_GO  = 1;
    localparam int B_CH  = 2;
    localparam int B_REF = 6;
    localparam int B_FMT = 7;
    localparam int B_CLK = 4;

    typedef logic [2:0] clk_sel_t;

    // True when the select code picks the external RC tick.
    function automatic logic sel_is_rc(input clk_sel_t s);
        return (s[1:0] == 2'b11);
    endfunction

    // Power-of-two exponent of the system-clock divider for a select code.
    function automatic logic [2:0] sel_div_exp(input clk_sel_t s);
        return {s[1:0], 1'b0} + 3'd1 + {2'b00, s[2]};
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
// Conversion-clock tick generator.
// Produces a one-cycle tick that marks the end of each conversion-clock
// period. The period is either a divided system clock or the external RC
// tick. Assumes active is low for at least one cycle between conversions,
// so every conversion starts from a cleared divider.
module sar_tick_gen
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  clk_sel_t sel,
    input  logic     rc_tick,
    output logic     tick
);

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] div_limit;
    logic             rc_mode;

    // Decode the terminal count of the divider from the select code.
    always_comb begin
        rc_mode   = sel_is_rc(sel);
        div_limit = (CNT_W'(1) << sel_div_exp(sel)) - CNT_W'(1);
    end

    // Free-run the divider only while a conversion is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!active || rc_mode) begin
            div_cnt <= '0;
        end else if (div_cnt == div_limit) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CNT_W'(1);
        end
    end

    // Pick the period-end event for the selected source.
    always_comb begin
        if (!active) begin
            tick = 1'b0;
        end else if (rc_mode) begin
            tick = rc_tick;
        end else begin
            tick = (div_cnt == div_limit);
        end
    end

endmodule

// File: rtl/sar_engine.sv
// Successive-approximation engine.
// One setup period is followed by RES_BITS decision periods, MSB first.
// Each period ends on a tick. The trial bit is kept when the comparator
// reports input >= trial. Assumes start and abort are never high together.
module sar_engine #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  logic                tick,
    input  logic                cmp_in,
    output logic                busy,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] kept_code,
    output logic                finish,
    output logic                done
);

    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic                setup;
    logic [RES_BITS-1:0] code;
    logic [RES_BITS-1:0] mask;

    // Apply the comparator decision to the bit under trial.
    always_comb begin
        kept_code = cmp_in ? code : (code & ~mask);
        finish    = busy && tick && !setup && mask[0] && !abort;
        dac_code  = code;
    end

    // Walk the trial mask from MSB to LSB, one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            setup <= 1'b0;
            code  <= '0;
            mask  <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                busy  <= 1'b1;
                setup <= 1'b1;
                code  <= '0;
                mask  <= '0;
            end else if (abort) begin
                busy  <= 1'b0;
                setup <= 1'b0;
                code  <= '0;
                mask  <= '0;
            end else if (busy && tick) begin
                if (setup) begin
                    setup <= 1'b0;
                    code  <= MSB_ONE;
                    mask  <= MSB_ONE;
                end else if (mask[0]) begin
                    busy <= 1'b0;
                    code <= '0;
                    mask <= '0;
                end else begin
                    mask <= mask >> 1;
                    code <= kept_code | (mask >> 1);
                end
            end
        end
    end

endmodule

// File: rtl/sar_regs.sv
// Register file of the sequencer.
// Holds the control and clock configuration, decodes start and abort from
// control writes, latches the per-conversion settings at start and stores
// the result. The result is laid out according to the format bit when read.
// Assumes DATA_W < RES_BITS <= 2*DATA_W.
module sar_regs
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                busy,
    input  logic                finish,
    input  logic [RES_BITS-1:0] kept_code,
    output logic                start,
    output logic                abort,
    output logic [1:0]          mux_sel,
    output logic                ref_sel,
    output clk_sel_t            run_clk
);

    localparam int PAD = 2 * DATA_W - RES_BITS;

    logic                en_q;
    logic [1:0]          chan_q;
    logic                ref_q;
    logic                fmt_q;
    clk_sel_t            clk_q;
    logic [1:0]          run_chan;
    logic                run_ref;
    logic [RES_BITS-1:0] res_q;
    logic [2*DATA_W-1:0] res_word;
    logic                ctl_wr;

    // Decode control writes into start and abort requests.
    always_comb begin
        ctl_wr = wr_en && (addr == A_CTL);
        start  = ctl_wr && !busy && wdata[B_GO] && wdata[B_EN];
        abort  = ctl_wr && busy && !(wdata[B_GO] && wdata[B_EN]);
    end

    // Store configuration fields on register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            chan_q <= '0;
            ref_q  <= 1'b0;
            fmt_q  <= 1'b0;
            clk_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTL) begin
                en_q   <= wdata[B_EN];
                chan_q <= wdata[B_CH +: 2];
                ref_q  <= wdata[B_REF];
                fmt_q  <= wdata[B_FMT];
            end else if (addr == A_CLKCFG) begin
                clk_q <= wdata[B_CLK +: 3];
            end
        end
    end

    // Freeze the settings used by the conversion being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_chan <= '0;
            run_ref  <= 1'b0;
            run_clk  <= '0;
        end else if (start) begin
            run_chan <= wdata[B_CH +: 2];
            run_ref  <= wdata[B_REF];
            run_clk  <= clk_q;
        end
    end

    // Capture the finished code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (finish) begin
            res_q <= kept_code;
        end
    end

    // Analog selects follow the register only between conversions.
    always_comb begin
        mux_sel = busy ? run_chan : chan_q;
        ref_sel = busy ? run_ref  : ref_q;
    end

    // Lay the result out right- or left-justified across two bytes.
    always_comb begin
        if (fmt_q) begin
            res_word = {{PAD{1'b0}}, res_q};
        end else begin
            res_word = {res_q, {PAD{1'b0}}};
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL: begin
                rdata[B_EN]       = en_q;
                rdata[B_GO]       = busy;
                rdata[B_CH +: 2]  = chan_q;
                rdata[B_REF]      = ref_q;
                rdata[B_FMT]      = fmt_q;
            end
            A_CLKCFG: rdata[B_CLK +: 3] = clk_q;
            A_RES_HI: rdata = res_word[2*DATA_W-1:DATA_W];
            default:  rdata = res_word[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/sar_seq_top.sv
// SAR conversion sequencer top level.
// Ties the register file, the conversion-clock tick generator and the
// approximation engine together. The analog front end is external.
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                rc_tick,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [1:0]          mux_sel,
    output logic                ref_sel,
    output logic                conv_done
);

    logic                busy;
    logic                start;
    logic                abort;
    logic                tick;
    logic                finish;
    logic [RES_BITS-1:0] kept_code;
    clk_sel_t            run_clk;

    sar_regs #(
        .RES_BITS (RES_BITS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .busy      (busy),
        .finish    (finish),
        .kept_code (kept_code),
        .start     (start),
        .abort     (abort),
        .mux_sel   (mux_sel),
        .ref_sel   (ref_sel),
        .run_clk   (run_clk)
    );

    sar_tick_gen #(
        .CNT_W (CNT_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (busy),
        .sel     (run_clk),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    sar_engine #(
        .RES_BITS (RES_BITS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .tick      (tick),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .dac_code  (dac_code),
        .kept_code (kept_code),
        .finish    (finish),
        .done      (conv_done)
    );

endmodule

// File: rtl/sar_seq_chk.sv
// Property checker for the SAR conversion sequencer, bound to the top.
module sar_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          addr,
    input logic                go_bit,
    input logic                en_bit,
    input logic                busy,
    input logic                conv_done,
    input logic [RES_BITS-1:0] dac_code,
    input logic [1:0]          mux_sel,
    input logic                ref_sel
);

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && go_bit && !en_bit && !busy) |=> !busy);

    p_dac_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> !busy);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && busy && !go_bit) |=> (!busy && !conv_done));

    p_mux_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));

    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ref_sel));

endmodule

bind sar_seq_top sar_seq_chk #(
    .RES_BITS (RES_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .go_bit    (wdata[1]),
    .en_bit    (wdata[0]),
    .busy      (busy),
    .conv_done (conv_done),
    .dac_code  (dac_code),
    .mux_sel   (mux_sel),
    .ref_sel   (ref_sel)
);

// File: tb/test_sar_seq_top.sv
// Directed bench for the SAR conversion sequencer; one task per scenario.
module test_sar_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rc_tick = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [1:0] mux_sel;
    logic       ref_sel;
    logic       conv_done;

    int checks = 0;
    int fails = 0;
    logic [9:0] ch_v [4];
    bit rc_run = 1'b0;
    int rc_div = 0;
    logic [9:0] last_res = 10'd0;

    always #10 clk = ~clk;

    // Ideal comparator on the selected channel.
    assign cmp_in = (ch_v[mux_sel] >= dac_code);

    // External RC tick: one cycle high every fourth cycle when enabled.
    always @(negedge clk) begin
        if (rc_run) begin
            rc_div  <= (rc_div + 1) % 4;
            rc_tick <= (rc_div == 3);
        end else begin
            rc_tick <= 1'b0;
        end
    end

    sar_seq_top i_sar_seq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rc_tick   (rc_tick),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .mux_sel   (mux_sel),
        .ref_sel   (ref_sel),
        .conv_done (conv_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(bit fmt, bit rf, logic [1:0] ch, bit go, bit en);
        return {fmt, rf, 2'b00, ch, go, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Counts cycles after the accepting edge until conv_done is seen.
    task automatic wait_done(input int limit, output int n, output bit seen);
        n = 0; seen = 1'b0;
        while (n < limit && !seen) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (conv_done) seen = 1'b1;
        end
        if (seen) begin
            @(negedge clk);
            chk("R7 done is one cycle", conv_done, 0);
        end
    endtask

    task automatic read_result(input bit fmt, input logic [9:0] v, input string tag);
        logic [7:0] hi, lo;
        rd(2'd2, hi); rd(2'd3, lo);
        if (fmt) begin
            chk({tag, " high right"}, hi, {6'b0, v[9:8]});
            chk({tag, " low right"}, lo, v[7:0]);
        end else begin
            chk({tag, " high left"}, hi, v[9:2]);
            chk({tag, " low left"}, lo, {v[1:0], 6'b0});
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 register reset", d, 0);
        end
        chk("R1 done idle", conv_done, 0);
        chk("R1 dac idle", dac_code, 0);
        chk("R1 mux idle", mux_sel, 0);
        chk("R1 ref idle", ref_sel, 0);
    endtask

    task automatic t_enable_gate;
        logic [7:0] d; int n; bit seen;
        wr(2'd1, 8'h00);
        ch_v[0] = 10'h123;
        wr(2'd0, ctl(1, 0, 2'd0, 1, 0));
        rd(2'd0, d);
        chk("R2 start ignored without enable", d[1], 0);
        wait_done(60, n, seen);
        chk("R2 no done without enable", seen, 0);
        wr(2'd0, ctl(1, 0, 2'd0, 1, 1));
        rd(2'd0, d);
        chk("R2 busy reads 1", d[1], 1);
        wait_done(100, n, seen);
        chk("R2 conversion completes", seen, 1);
        rd(2'd0, d);
        chk("R7 busy cleared after done", d[1], 0);
        read_result(1, ch_v[0], "R5");
        last_res = ch_v[0];
    endtask

    task automatic t_timing(input logic [2:0] sel, input int div);
        int n; bit seen;
        wr(2'd1, {1'b0, sel, 4'b0});
        ch_v[0] = 10'h2D6;
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = ctl(1, 0, 2'd0, 1, 1);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 dac zero in setup", dac_code, 0);
        n = 0; seen = 1'b0;
        while (n < 11 * div + 4 && !seen) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == div) chk("R5 first trial", dac_code, 10'h200);
            if (conv_done) seen = 1'b1;
        end
        chk("R3 conversion length", n, 11 * div);
        read_result(1, ch_v[0], "R3");
        last_res = ch_v[0];
    endtask

    task automatic t_values;
        logic [9:0] vals [5];
        int n; bit seen;
        vals[0] = 10'h000; vals[1] = 10'h3FF; vals[2] = 10'h155;
        vals[3] = 10'h001; vals[4] = 10'h2AA;
        wr(2'd1, 8'h00);
        for (int i = 0; i < 5; i++) begin
            ch_v[i % 4] = vals[i];
            wr(2'd0, ctl(1, 0, 2'(i % 4), 1, 1));
            wait_done(100, n, seen);
            chk("R5 done seen", seen, 1);
            read_result(1, vals[i], "R6 R5");
            wr(2'd0, ctl(0, 0, 2'(i % 4), 0, 1));
            read_result(0, vals[i], "R6");
            last_res = vals[i];
        end
    endtask

    task automatic t_abort;
        logic [7:0] d; int n; bit seen;
        wr(2'd1, 8'h00);
        ch_v[2] = 10'h0AA;
        wr(2'd0, ctl(1, 0, 2'd2, 1, 1));
        repeat (7) @(negedge clk);
        wr(2'd0, ctl(1, 0, 2'd2, 0, 1));
        rd(2'd0, d);
        chk("R8 busy cleared by abort", d[1], 0);
        chk("R8 dac idle after abort", dac_code, 0);
        wait_done(60, n, seen);
        chk("R8 no done after abort", seen, 0);
        read_result(1, last_res, "R8 result kept");
    endtask

    task automatic t_mux_hold;
        int n; bit seen;
        wr(2'd1, 8'h00);
        wr(2'd0, ctl(0, 0, 2'd1, 0, 1));
        chk("R9 idle mux follows", mux_sel, 1);
        chk("R9 idle ref follows", ref_sel, 0);
        wr(2'd0, ctl(0, 1, 2'd3, 0, 1));
        chk("R9 idle mux follows 3", mux_sel, 3);
        chk("R9 idle ref follows 1", ref_sel, 1);
        ch_v[1] = 10'h1C3;
        ch_v[3] = 10'h3F0;
        wr(2'd0, ctl(1, 0, 2'd1, 1, 1));
        chk("R9 mux at start", mux_sel, 1);
        wr(2'd0, ctl(1, 1, 2'd3, 1, 1));
        chk("R9 mux held", mux_sel, 1);
        chk("R9 ref held", ref_sel, 0);
        wait_done(100, n, seen);
        chk("R9 done seen", seen, 1);
        read_result(1, ch_v[1], "R9 held channel");
        last_res = ch_v[1];
        chk("R9 mux after done", mux_sel, 3);
        chk("R9 ref after done", ref_sel, 1);
    endtask

    task automatic t_rc(input logic [2:0] sel);
        logic [7:0] d; int n; bit seen;
        rc_run = 1'b0;
        wr(2'd1, {1'b0, sel, 4'b0});
        ch_v[0] = 10'h26B;
        wr(2'd0, ctl(1, 0, 2'd0, 1, 1));
        repeat (100) @(negedge clk);
        rd(2'd0, d);
        chk("R4 stalls without rc tick", d[1], 1);
        chk("R4 still in setup", dac_code, 0);
        rc_run = 1'b1;
        wait_done(400, n, seen);
        chk("R4 completes on rc ticks", seen, 1);
        read_result(1, ch_v[0], "R4");
        last_res = ch_v[0];
        rc_run = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ch_v[i] = 10'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_gate();
        t_timing(3'b000, 2);
        t_timing(3'b100, 4);
        t_timing(3'b001, 8);
        t_timing(3'b101, 16);
        t_timing(3'b010, 32);
        t_timing(3'b110, 64);
        t_values();
        t_abort();
        t_mux_hold();
        t_rc(3'b011);
        t_rc(3'b111);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule